// File: doc/BRIEF.md
# Serial Result Shifter with Busy Indicator

This block is the output side of a converter's serial port. When a conversion finishes, an end-of-conversion strobe delivers a 12-bit straight-binary result. The block then sends that result most significant bit first on a serial data line. An external serial clock paces the bits and an active-low chip select frames each transfer. Whenever the block is not driving the data line, it drops the line's output enable, so the pad is high impedance.

The framing depends on the level of chip select when the strobe arrives. If chip select is high at that moment, the port works in normal mode: the first bit appears when chip select falls, and twelve clock falling edges finish the word. If chip select is already low, the port works in busy-indicator mode: the line is driven low at once, which a host can use as a completion interrupt. The first clock falling edge then brings out the first bit, and thirteen falling edges finish the word.

The block also counts serial clock falling edges inside each chip-select frame. A frame that closes after a small number of edges is reported to a mode sequencer as a short cycle. Serial clock and chip select are taken as already synchronised to the block clock, and the block detects their edges in that clock domain.

Top module: `serial_result_shifter`

## Requirements
- R1: After reset the output enable is low and no short-cycle pulse is present.
- R2: If chip select is high when the end-of-conversion strobe arrives, the output enable stays low. The cycle after chip select falls, the output enable is high and the data line carries result bit 11.
- R3: In normal mode, serial clock falling edges 1 to 11 put out bits 10 down to 0 in turn. A serial clock rising edge leaves the data line unchanged. The 12th falling edge drops the output enable.
- R4: If chip select is low when the strobe arrives, the data line is driven low from the next cycle. It stays low, through idle cycles and through clock rising edges, until the first serial clock falling edge. That edge puts out bit 11.
- R5: In busy-indicator mode, falling edges 2 to 12 put out bits 10 down to 0, and the 13th falling edge drops the output enable.
- R6: A rising edge of chip select drops the output enable the following cycle, whatever the position in the word.
- R7: Serial clock falling edges after the word is complete, as in a 16-clock frame, leave the output enable low.
- R8: When chip select rises after 2 to 8 serial clock falling edges in the frame, the short-cycle output pulses high for exactly one cycle, and the edge-count output then gives the number of edges. Frames of 0, 1, or 9 or more edges produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Serial clock, synchronised, idles high |
| csN | input | 1 | Active-low chip select, synchronised |
| eocStrobe | input | 1 | One-cycle end-of-conversion strobe |
| eocData | input | 12 | Conversion result, straight binary |
| sdoData | output | 1 | Serial data value |
| sdoOe | output | 1 | Output enable for the serial data pad |
| shortCycle | output | 1 | One-cycle pulse marking a short frame |
| shortEdges | output | 5 | Falling-edge count of the short frame |

## Verification
The hardest situation to reach is busy-indicator mode. It needs chip select to be low before the end-of-conversion strobe arrives, and the reply has to be followed across thirteen edges, not twelve. The stimulus therefore lowers chip select first and idles for a while. It then fires the strobe, steps through the idle and rising-edge half cycles while checking that the line stays low, and only then starts the clock falls. The short-cycle boundaries are reached with frames of exactly 1, 2, 8 and 9 edges.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  typedef struct packed {
    logic load;
    logic holdLow;
    logic present;
    logic advance;
    logic quiet;
  } shiftCmd_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
#(
  parameter int W = 12,
  parameter int SHORT_MIN = 2,
  parameter int SHORT_MAX = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkIn,
  input  logic             csN,
  input  logic             eocStrobe,
  output shiftCmd_t        cmd,
  output logic             shortCycle,
  output logic [CNT_W-1:0] shortEdges
);
  localparam int BIT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic sclkPrev, csPrev, sclkFall, csFall, csRise;
  logic armed, active;
  logic [BIT_W-1:0] bitsOut;
  logic [CNT_W-1:0] edgeCnt;

  assign sclkFall = sclkPrev & ~sclkIn;
  assign csFall   = csPrev & ~csN;
  assign csRise   = ~csPrev & csN;

  always_comb begin
    cmd = '0;
    if (eocStrobe) begin
      cmd.load    = 1'b1;
      cmd.holdLow = ~csN;
      cmd.quiet   = csN;
    end else if (csRise) begin
      cmd.quiet = 1'b1;
    end else if (csFall && armed) begin
      cmd.present = 1'b1;
    end else if (sclkFall && active && !csN) begin
      if (bitsOut == '0)                   cmd.present = 1'b1;
      else if (bitsOut < BIT_W'(W))        cmd.advance = 1'b1;
      else                                 cmd.quiet   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPrev   <= 1'b1;
      csPrev     <= 1'b1;
      armed      <= 1'b0;
      active     <= 1'b0;
      bitsOut    <= '0;
      edgeCnt    <= '0;
      shortCycle <= 1'b0;
      shortEdges <= '0;
    end else begin
      sclkPrev <= sclkIn;
      csPrev   <= csN;
      if (eocStrobe) begin
        armed   <= csN;
        active  <= ~csN;
        bitsOut <= '0;
      end else if (csRise) begin
        active <= 1'b0;
      end else if (csFall && armed) begin
        armed   <= 1'b0;
        active  <= 1'b1;
        bitsOut <= BIT_W'(1);
      end else if (sclkFall && active && !csN) begin
        if (bitsOut == BIT_W'(W)) active  <= 1'b0;
        else                      bitsOut <= bitsOut + 1'b1;
      end
      if (csFall)
        edgeCnt <= '0;
      else if (sclkFall && !csN && edgeCnt != CNT_MAX)
        edgeCnt <= edgeCnt + 1'b1;
      shortCycle <= csRise && (edgeCnt >= CNT_W'(SHORT_MIN)) && (edgeCnt <= CNT_W'(SHORT_MAX));
      if (csRise) shortEdges <= edgeCnt;
    end
  end

  // R8: a short-cycle pulse lasts one cycle and reports an in-range count
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    shortCycle |=> !shortCycle);
  a_r8_count_range: assert property (@(posedge clk) disable iff (!rstN)
    shortCycle |-> (shortEdges >= CNT_W'(SHORT_MIN) && shortEdges <= CNT_W'(SHORT_MAX)));
  // R5: the bit counter never passes the word length
  a_r5_bits_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitsOut <= BIT_W'(W));
endmodule

// File: rtl/shift_data.sv
module shift_data
  import shifter_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  shiftCmd_t    cmd,
  input  logic [W-1:0] eocData,
  output logic         sdoData,
  output logic         sdoOe
);
  logic [W-1:0] shiftReg;
  logic holdFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      holdFlag <= 1'b0;
      sdoOe    <= 1'b0;
    end else begin
      if (cmd.load)         shiftReg <= eocData;
      else if (cmd.advance) shiftReg <= {shiftReg[W-2:0], 1'b0};
      if (cmd.holdLow) begin
        sdoOe    <= 1'b1;
        holdFlag <= 1'b1;
      end else if (cmd.present) begin
        sdoOe    <= 1'b1;
        holdFlag <= 1'b0;
      end else if (cmd.quiet) begin
        sdoOe    <= 1'b0;
        holdFlag <= 1'b0;
      end
    end
  end

  assign sdoData = holdFlag ? 1'b0 : shiftReg[W-1];

  // R3: the controller only advances bits while the pad is driven
  a_r3_advance_driven: assert property (@(posedge clk) disable iff (!rstN)
    cmd.advance |-> sdoOe);
endmodule

// File: rtl/serial_result_shifter.sv
module serial_result_shifter
  import shifter_pkg::*;
#(
  parameter int W = 12,
  parameter int SHORT_MIN = 2,
  parameter int SHORT_MAX = 8,
  parameter int CNT_W = $clog2(W + 4) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkIn,
  input  logic             csN,
  input  logic             eocStrobe,
  input  logic [W-1:0]     eocData,
  output logic             sdoData,
  output logic             sdoOe,
  output logic             shortCycle,
  output logic [CNT_W-1:0] shortEdges
);
  shiftCmd_t cmd;

  shift_ctrl #(.W(W), .SHORT_MIN(SHORT_MIN), .SHORT_MAX(SHORT_MAX), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csN(csN), .eocStrobe(eocStrobe),
    .cmd(cmd), .shortCycle(shortCycle), .shortEdges(shortEdges)
  );

  shift_data #(.W(W)) u_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .eocData(eocData),
    .sdoData(sdoData), .sdoOe(sdoOe)
  );

  // R6: chip select high always leaves the pad released on the next cycle
  a_r6_cs_high_release: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !sdoOe);
  // R4: strobe with chip select low drives the line low next cycle
  a_r4_busy_low: assert property (@(posedge clk) disable iff (!rstN)
    (eocStrobe && !csN) |=> (sdoOe && !sdoData));
  // R2: strobe with chip select high keeps the pad released
  a_r2_no_early_drive: assert property (@(posedge clk) disable iff (!rstN)
    (eocStrobe && csN) |=> !sdoOe);
endmodule

// File: tb/tb_serial_result_shifter.sv
module tb_serial_result_shifter;
  localparam int W = 12;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b1;
  logic csN = 1'b1;
  logic eocStrobe = 1'b0;
  logic [W-1:0] eocData = '0;
  logic sdoData, sdoOe, shortCycle;
  logic [CNT_W-1:0] shortEdges;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic dataOn;
    logic sdo;
    logic oe;
    logic shortOn;
    logic shortV;
    int   edges;
    string tag;
  } expItem_t;

  expItem_t q[$];

  always #10 clk = ~clk;

  serial_result_shifter dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csN(csN), .eocStrobe(eocStrobe),
    .eocData(eocData), .sdoData(sdoData), .sdoOe(sdoOe),
    .shortCycle(shortCycle), .shortEdges(shortEdges)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      wait (q.size() > 0);
      begin
        expItem_t e;
        e = q.pop_front();
        checks++;
        if (sdoOe !== e.oe || (e.dataOn && sdoData !== e.sdo) ||
            (e.shortOn && (shortCycle !== e.shortV ||
                           (e.shortV && int'(shortEdges) != e.edges)))) begin
          fails++;
          $display("FAIL %s: oe=%b sdo=%b short=%b edges=%0d expected oe=%b sdo=%b short=%b edges=%0d",
                   e.tag, sdoOe, sdoData, shortCycle, shortEdges, e.oe, e.sdo, e.shortV, e.edges);
        end
      end
    end
  end

  task automatic expectOut(input logic oe, input logic dataOn, input logic sdo, input string tag);
    expItem_t e;
    e.dataOn = dataOn; e.sdo = sdo; e.oe = oe;
    e.shortOn = 1'b0; e.shortV = 1'b0; e.edges = 0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic expectShort(input logic oe, input logic sv, input int edges, input string tag);
    expItem_t e;
    e.dataOn = 1'b0; e.sdo = 1'b0; e.oe = oe;
    e.shortOn = 1'b1; e.shortV = sv; e.edges = edges; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic setCs(input logic v);
    csN = v;
    step();
  endtask

  task automatic fallEdge();
    sclkIn = 1'b0;
    step();
  endtask

  task automatic riseEdge();
    sclkIn = 1'b1;
    step();
  endtask

  task automatic fireEoc(input logic [W-1:0] d);
    eocData = d;
    eocStrobe = 1'b1;
    step();
    eocStrobe = 1'b0;
  endtask

  task automatic shortFrame(input int n, input string tag);
    fireEoc(12'h5A3);
    setCs(1'b0);
    for (int i = 0; i < n; i++) begin
      fallEdge();
      riseEdge();
    end
    setCs(1'b1);
    expectShort(1'b0, (n >= 2 && n <= 8), n, tag);
    step();
    expectShort(1'b0, 1'b0, 0, {tag, " pulse ends"});
    step();
  endtask

  initial begin
    logic [W-1:0] d;
    step(); step();
    // R1: reset state
    expectShort(1'b0, 1'b0, 0, "R1 reset");
    rstN = 1'b1;
    step(); step();

    // Normal mode, two data words
    for (int k = 0; k < 2; k++) begin
      d = (k == 0) ? 12'hA5C : 12'h3C9;
      fireEoc(d);
      expectOut(1'b0, 1'b0, 1'b0, "R2 no drive before cs fall");
      step();
      setCs(1'b0);
      expectOut(1'b1, 1'b1, d[11], "R2 bit11 on cs fall");
      for (int b = 10; b >= 0; b--) begin
        fallEdge();
        expectOut(1'b1, 1'b1, d[b], "R3 normal bit");
        riseEdge();
        expectOut(1'b1, 1'b1, d[b], "R3 stable on rise");
      end
      fallEdge();
      expectOut(1'b0, 1'b0, 1'b0, "R3 12th fall releases");
      riseEdge();
      for (int x = 0; x < 4; x++) begin
        fallEdge();
        expectOut(1'b0, 1'b0, 1'b0, "R7 extra clocks");
        riseEdge();
      end
      setCs(1'b1);
      expectShort(1'b0, 1'b0, 0, "R8 long frame no pulse");
      step();
    end

    // Busy-indicator mode, two data words
    for (int k = 0; k < 2; k++) begin
      d = (k == 0) ? 12'hF0F : 12'h801;
      setCs(1'b0);
      step(); step();
      expectOut(1'b0, 1'b0, 1'b0, "R4 idle before eoc");
      fireEoc(d);
      expectOut(1'b1, 1'b1, 1'b0, "R4 driven low at eoc");
      step();
      expectOut(1'b1, 1'b1, 1'b0, "R4 holds low idle");
      sclkIn = 1'b0; sclkIn = 1'b1;
      step();
      expectOut(1'b1, 1'b1, 1'b0, "R4 holds low no fall");
      fallEdge();
      expectOut(1'b1, 1'b1, d[11], "R4 first fall bit11");
      riseEdge();
      expectOut(1'b1, 1'b1, d[11], "R4 bit11 stable on rise");
      for (int b = 10; b >= 0; b--) begin
        fallEdge();
        expectOut(1'b1, 1'b1, d[b], "R5 busy bit");
        riseEdge();
      end
      fallEdge();
      expectOut(1'b0, 1'b0, 1'b0, "R5 13th fall releases");
      riseEdge();
      fallEdge();
      expectOut(1'b0, 1'b0, 1'b0, "R7 extra clock busy");
      riseEdge();
      setCs(1'b1);
      step();
    end

    // R6: chip select rise mid-word
    d = 12'hFFF;
    fireEoc(d);
    setCs(1'b0);
    fallEdge(); riseEdge();
    fallEdge(); riseEdge();
    fallEdge(); riseEdge();
    expectOut(1'b1, 1'b1, 1'b1, "R6 driving before cs rise");
    setCs(1'b1);
    expectOut(1'b0, 1'b0, 1'b0, "R6 cs rise releases");
    step();
    // R6 in busy mode while holding low
    setCs(1'b0);
    fireEoc(12'h123);
    expectOut(1'b1, 1'b1, 1'b0, "R6 busy low before rise");
    setCs(1'b1);
    expectOut(1'b0, 1'b0, 1'b0, "R6 cs rise releases busy");
    step();

    // R8: short-cycle boundaries
    shortFrame(0, "R8 zero edges");
    shortFrame(1, "R8 one edge");
    shortFrame(2, "R8 two edges");
    shortFrame(4, "R8 four edges");
    shortFrame(8, "R8 eight edges");
    shortFrame(9, "R8 nine edges");

    wait (q.size() == 0);
    #1;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule